// File: doc/BRIEF.md
# Quad-Line Serial Flash Read Sequencer

This block is the host side of a read link to a serial NOR flash that runs with all four data lines in every phase at single data rate. For each accepted request it lowers chip select and produces the serial clock at half the system clock rate. It then sends a read command of 0Ch, the 32-bit address and one mode byte on four lines. Next it releases the lines for a number of dummy cycles equal to the request's latency code. Finally it samples eight nibbles from the flash and returns them as one 32-bit word with a one-cycle acknowledge.

When a request asks for continuous read, the mode byte sent is A0h. The flash then expects the next transaction to begin directly with the address, so the block leaves out the command byte on its following transfer. A request without continuous read sends mode byte 00h, and the transfer after it carries the command byte again. A requester raises `req` with the address, latency code and continuous flag stable, and holds it until `ack` pulses.

Top module: `quad_flash_reader`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, `io_oe` is 0 and `ack` is 0, and they stay so while `req` is low.
- R2: `sck` starts low and alternates every system clock while `cs_n` is low, so one serial cycle is two system clocks. `cs_n` falls one system clock before the first rising `sck`.
- R3: If the previous transaction did not send mode byte A0h (and always after reset), the first two serial cycles carry command byte 0Ch. The upper nibble goes first, and `io_o[3]` is the highest bit of each nibble.
- R4: The 32-bit address follows in eight serial cycles, most significant nibble first.
- R5: One mode byte follows the address in two serial cycles. It is A0h when `cont_en` was 1 in the request and 00h otherwise.
- R6: A transaction that follows one which sent A0h begins directly with the address and sends no command byte.
- R7: Between the mode byte and the data there are exactly `lat_code` dummy serial cycles (0 to 15, so 1000b gives eight). `io_oe` is 1 while command, address and mode are driven, and 0 during the dummy and data cycles.
- R8: `io_i` is sampled on each of the eight rising `sck` edges of the data phase, first nibble most significant. In the clock after the last sample, `cs_n` rises, `sck` is low and `ack` is high for one cycle with `rdata` holding the word.
- R9: `cs_n` stays high for at least two system clocks (one serial cycle) between transactions.
- R10: `io_oe` is never 1 while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request, held until ack |
| addr | input | 32 | Flash byte address |
| lat_code | input | 4 | Dummy cycle count for this read |
| cont_en | input | 1 | Arm continuous read (mode A0h) |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read word, valid with ack |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock, system clock / 2 |
| io_o | output | 4 | Data lines driven by the host |
| io_oe | output | 1 | Output enable for io_o |
| io_i | input | 4 | Data lines as seen from the flash |

## Verification
A behavioural reference in the bench builds the expected per-clock waveform of `cs_n`, `sck`, `io_oe`, driven nibbles and `ack` for every request. It checks the real waveform against it on every clock. The request sequence alternates continuous and plain reads, so a command-less transfer after A0h is told apart from one that follows 00h. Latency codes 0, 1, 3, 8 and 15 separate an off-by-one dummy count and a missing zero-dummy path. Asymmetric addresses and data words expose nibble order and line order errors.

// File: rtl/quad_flash_reader.sv
module quad_flash_reader #(
  parameter int         ADDR_W    = 32,
  parameter int         DATA_W    = 32,
  parameter int         LAT_W     = 4,
  parameter logic [7:0] READ_CMD  = 8'h0C,
  parameter logic [7:0] MODE_CONT = 8'hA0,
  parameter logic [7:0] MODE_STOP = 8'h00,
  parameter int         GAP_CYC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LAT_W-1:0]  lat_code,
  input  logic              cont_en,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              cs_n,
  output logic              sck,
  output logic [3:0]        io_o,
  output logic              io_oe,
  input  logic [3:0]        io_i
);

  localparam int TX_W     = ADDR_W + 16;
  localparam int OUT_NIB  = TX_W / 4;
  localparam int DATA_NIB = DATA_W / 4;
  localparam int CNT_W    = 8;

  typedef enum logic [2:0] {S_IDLE, S_OUT, S_DUMMY, S_DATA, S_GAP} st_t;

  st_t               st;
  logic              ph;
  logic              armed;
  logic              cont_q;
  logic [LAT_W-1:0]  lat_q;
  logic [CNT_W-1:0]  cnt;
  logic [TX_W-1:0]   tx;
  logic [DATA_W-1:0] sh;
  logic [7:0]        mode_b;

  assign mode_b = cont_en ? MODE_CONT : MODE_STOP;
  assign io_o   = tx[TX_W-1 -: 4];
  assign sck    = ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ph     <= 1'b0;
      armed  <= 1'b0;
      cont_q <= 1'b0;
      lat_q  <= '0;
      cnt    <= '0;
      tx     <= '0;
      sh     <= '0;
      rdata  <= '0;
      ack    <= 1'b0;
      cs_n   <= 1'b1;
      io_oe  <= 1'b0;
    end else begin
      ack <= 1'b0;
      unique case (st)
        S_IDLE: if (req) begin
          cs_n   <= 1'b0;
          ph     <= 1'b0;
          io_oe  <= 1'b1;
          lat_q  <= lat_code;
          cont_q <= cont_en;
          st     <= S_OUT;
          if (armed) begin
            tx  <= {addr, mode_b, 8'h00};
            cnt <= CNT_W'(OUT_NIB - 3);
          end else begin
            tx  <= {READ_CMD, addr, mode_b};
            cnt <= CNT_W'(OUT_NIB - 1);
          end
        end
        S_OUT: begin
          ph <= ~ph;
          if (ph) begin
            tx <= tx << 4;
            if (cnt == '0) begin
              armed <= cont_q;
              io_oe <= 1'b0;
              if (lat_q != '0) begin
                st  <= S_DUMMY;
                cnt <= CNT_W'(lat_q) - 1'b1;
              end else begin
                st  <= S_DATA;
                cnt <= CNT_W'(DATA_NIB - 1);
              end
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        S_DUMMY: begin
          ph <= ~ph;
          if (ph) begin
            if (cnt == '0) begin
              st  <= S_DATA;
              cnt <= CNT_W'(DATA_NIB - 1);
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        S_DATA: begin
          ph <= ~ph;
          if (!ph) begin
            sh <= {sh[DATA_W-5:0], io_i};
          end else if (cnt == '0) begin
            cs_n  <= 1'b1;
            ack   <= 1'b1;
            rdata <= sh;
            st    <= S_GAP;
            cnt   <= CNT_W'(GAP_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_GAP: begin
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10
  oe_inside_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe |-> !cs_n);

  // R2
  sck_alternates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sck) |=> !sck);

  // R8
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R8
  ack_on_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (ack && !sck));

  // R9
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> cs_n);

endmodule

// File: tb/quad_flash_reader_tb_top.sv
module quad_flash_reader_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] addr = '0;
  logic [3:0]  lat_code = '0;
  logic        cont_en = 1'b0;
  logic        ack;
  logic [31:0] rdata;
  logic        cs_n;
  logic        sck;
  logic [3:0]  io_o;
  logic        io_oe;
  logic [3:0]  io_i = '0;

  int checks = 0;
  int errors = 0;
  bit model_armed = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic       cs_n;
    logic       sck;
    logic       oe;
    logic [3:0] io;
    logic [3:0] drv;
    logic       ack;
    string      tag;
  } ent_t;

  ent_t exp_q[$];

  always #4 clk = ~clk;

  quad_flash_reader dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .lat_code(lat_code),
    .cont_en(cont_en), .ack(ack), .rdata(rdata), .cs_n(cs_n), .sck(sck),
    .io_o(io_o), .io_oe(io_oe), .io_i(io_i)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic void push_serial(input logic oe, input logic [3:0] io,
                                      input logic [3:0] drv, input string tag);
    for (int h = 0; h < 2; h++) begin
      ent_t e;
      e.cs_n = 1'b0; e.sck = logic'(h); e.oe = oe; e.io = io;
      e.drv = drv; e.ack = 1'b0; e.tag = tag;
      exp_q.push_back(e);
    end
  endfunction

  task automatic run(input logic [31:0] a, input logic [3:0] lat,
                     input bit cont, input logic [31:0] w);
    logic [7:0] mb;
    ent_t e;
    exp_q.delete();
    if (!model_armed) begin
      push_serial(1'b1, 4'h0, 4'h0, "R3");
      push_serial(1'b1, 4'hC, 4'h0, "R3");
    end
    for (int i = 0; i < 8; i++) push_serial(1'b1, a[31-4*i -: 4], 4'h0, "R4");
    mb = cont ? 8'hA0 : 8'h00;
    push_serial(1'b1, mb[7:4], 4'h0, model_armed ? "R6" : "R5");
    push_serial(1'b1, mb[3:0], 4'h0, "R5");
    for (int i = 0; i < int'(lat); i++) push_serial(1'b0, 4'h0, 4'h0, "R7");
    for (int i = 0; i < 8; i++) push_serial(1'b0, 4'h0, w[31-4*i -: 4], "R8");
    e.cs_n = 1'b1; e.sck = 1'b0; e.oe = 1'b0; e.io = 4'h0; e.drv = 4'h0;
    e.ack = 1'b1; e.tag = "R8";
    exp_q.push_back(e);
    e.ack = 1'b0; e.tag = "R9";
    exp_q.push_back(e);
    exp_q.push_back(e);
    model_armed = cont;

    @(negedge clk);
    req = 1'b1; addr = a; lat_code = lat; cont_en = cont;
    foreach (exp_q[k]) begin
      @(posedge clk);
      @(negedge clk);
      chk(cs_n == exp_q[k].cs_n, exp_q[k].tag, "cs_n", 32'(cs_n), 32'(exp_q[k].cs_n));
      chk(sck == exp_q[k].sck, "R2", "sck", 32'(sck), 32'(exp_q[k].sck));
      chk(io_oe == exp_q[k].oe, "R7", "io_oe", 32'(io_oe), 32'(exp_q[k].oe));
      chk(ack == exp_q[k].ack, "R8", "ack", 32'(ack), 32'(exp_q[k].ack));
      if (exp_q[k].oe)
        chk(io_o == exp_q[k].io, exp_q[k].tag, "io_o", 32'(io_o), 32'(exp_q[k].io));
      if (exp_q[k].ack) begin
        chk(rdata == w, "R8", "rdata", rdata, w);
        req = 1'b0;
      end
      io_i = exp_q[k].drv;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(cs_n == 1'b1 && sck == 1'b0 && io_oe == 1'b0 && ack == 1'b0, "R1",
          "idle outputs", {28'h0, cs_n, sck, io_oe, ack}, 32'h8);
    end
    run(32'h0000_0020, 4'd8,  1'b1, 32'hA5A5_A5A5);
    run(32'h1234_5678, 4'd8,  1'b1, 32'h0123_4567);
    run(32'hFEDC_BA98, 4'd0,  1'b0, 32'h89AB_CDEF);
    run(32'h0000_0000, 4'd15, 1'b0, 32'hFFFF_0000);
    run(32'h8000_0001, 4'd1,  1'b1, 32'h0F1E_2D3C);
    run(32'h7654_3210, 4'd3,  1'b0, 32'h5A5A_C3C3);
    run(32'h0000_0100, 4'd2,  1'b0, 32'h1357_9BDF);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule